// File: doc/BRIEF.md
# Modal RPN Stack Calculator

This block is a small reverse-Polish calculator that works on signed 8-bit values held in an internal stack of 32 entries. Four single-cycle key pulses drive it: an entry key, a removal key, a mode key and a clear key. The mode key moves through three modes. The first two keys mean something different in each mode: stack entry and removal in the base mode, add and subtract in the arithmetic mode, and negate and exchange in the extra mode.

Each arithmetic or exchange command runs as a short sequence of internal steps. The block pops the operands into two holding registers, computes with a carry-lookahead adder whose second input can be inverted, and pushes the result back. A sticky overflow flag records the signed-overflow outcome of the last add, subtract or negate. The depth, the top value and the mode are visible on the ports, so the block can feed a display directly. The key inputs are expected to be debounced single pulses.

Top module: `rpn_calc`

## Requirements
- R1: After reset, or in the cycle after `clearKey` is high (even during a busy sequence), depth is 0, `isEmpty`=1, `modeOut`=0, `ovfFlag`=0 and `busy`=0.
- R2: While not busy, a `modeKey` pulse steps `modeOut` 0→1→2→0. Keys other than `clearKey` are ignored while `busy`=1.
- R3: In mode 0, `pushKey` places `numIn` on top and raises depth by one. When depth is 32 (`isFull`=1) the push is ignored: depth and `topOut` stay the same.
- R4: In mode 0, `popKey` removes the top entry. When depth is 0 the pop is ignored and depth stays 0.
- R5: In mode 1, `pushKey` (add) replaces the entry below the top (X) and the top (Y) with (X+Y) mod 256, so depth drops by one.
- R6: In mode 1, `popKey` (subtract) replaces X and Y with (X−Y) mod 256.
- R7: `ovfFlag` is written when each add, subtract or negate finishes. It is set exactly when the true signed result lies outside −128..127. Push, pop and exchange leave it unchanged.
- R8: In mode 2, `pushKey` (negate) replaces the top with (0−top) mod 256. Negating −128 (code 0x80) returns 0x80 and sets `ovfFlag`.
- R9: In mode 2, `popKey` (exchange) swaps the top two entries and leaves depth unchanged.
- R10: An add, subtract or exchange with depth below 2, or a negate with depth 0, is ignored: stack and `ovfFlag` are unchanged. After any command in modes 1 or 2, whether run or ignored, `modeOut` returns to 0.
- R11: Push and pop finish at the key's clock edge with no busy cycles. `busy` stays high for 3 cycles for add or subtract, 2 for negate and 4 for exchange.
- R12: `topOut` shows the top entry, or 0 when the stack is empty. `isFull` is 1 exactly when depth equals 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pushKey | input | 1 | Key 0 pulse: push / add / negate |
| popKey | input | 1 | Key 1 pulse: pop / subtract / exchange |
| modeKey | input | 1 | Key 2 pulse: advance mode |
| clearKey | input | 1 | Key 3 pulse: clear calculator |
| numIn | input | 8 | Value to push |
| topOut | output | 8 | Current top of stack |
| depth | output | 6 | Number of stored entries |
| isEmpty | output | 1 | Stack holds no entries |
| isFull | output | 1 | Stack holds 32 entries |
| ovfFlag | output | 1 | Signed overflow of last arithmetic result |
| modeOut | output | 2 | Current key mode (0, 1 or 2) |
| busy | output | 1 | A command sequence is running |

## Verification
The properties assume that keys arrive as pulses of one cycle and that at most one of the first three keys is high in any cycle. The next-cycle checks on depth and mode rely on this, because entry has priority over removal, and removal over the mode key. The stimulus presses one key at a time and holds it for exactly one cycle. It waits for `busy` to drop before the next press, except in the test that clears the block in the middle of a sequence. The sweeps cover every negate operand and a grid of add and subtract operand pairs that includes the sign boundaries.

// File: rtl/rpn_pkg.sv
package rpn_pkg;

  typedef enum logic [1:0] {
    MODE_BASE  = 2'd0,
    MODE_ARITH = 2'd1,
    MODE_EXTRA = 2'd2
  } mode_t;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_NEG  = 2'd2,
    OP_SWAP = 2'd3
  } op_t;

  typedef enum logic [1:0] {
    SRC_SWITCH = 2'd0,
    SRC_ALU    = 2'd1,
    SRC_OLD    = 2'd2,
    SRC_NEW    = 2'd3
  } src_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic pushEn;
    logic popEn;
    logic clearEn;
    logic setOvf;
    src_t pushSrc;
    op_t  aluOp;
  } strobe_t;

endpackage

// File: rtl/rpn_cla.sv
module rpn_cla #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum
);

  logic [W-1:0] prop;
  logic [W-1:0] gen;
  logic [W-1:0] carry;

  assign prop = a ^ b;
  assign gen  = a & b;

  // Flattened lookahead: each carry is a sum of generate terms
  // qualified by the propagate chain above them.
  function automatic logic carryAt(input int n, input logic [W-1:0] gv,
                                   input logic [W-1:0] pv, input logic c0);
    logic res;
    logic term;
    res = c0;
    for (int k = 0; k < n; k++) res = res & pv[k];
    for (int j = 0; j < n; j++) begin
      term = gv[j];
      for (int k = j + 1; k < n; k++) term = term & pv[k];
      res = res | term;
    end
    return res;
  endfunction

  assign carry[0] = cin;

  genvar i;
  generate
    for (i = 1; i < W; i++) begin : g_carry
      assign carry[i] = carryAt(i, gen, prop, cin);
    end
    for (i = 0; i < W; i++) begin : g_sum
      assign sum[i] = prop[i] ^ carry[i];
    end
  endgenerate

endmodule

// File: rtl/rpn_datapath.sv
module rpn_datapath
  import rpn_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] numIn,
  output logic [DATA_W-1:0] topOut,
  output logic [CNT_W-1:0]  depth,
  output logic              isEmpty,
  output logic              isFull,
  output logic              ovfFlag
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  sp;
  logic [DATA_W-1:0] tmpNew;   // most recent pop
  logic [DATA_W-1:0] tmpOld;   // pop before that
  logic [IDX_W-1:0]  headIdx;
  logic [IDX_W-1:0]  wrIdx;

  assign headIdx = IDX_W'(sp - CNT_W'(1));
  assign wrIdx   = IDX_W'(sp);

  // ALU operand selection
  logic [DATA_W-1:0] opA, opB, bXor, aluSum, pushData;
  logic              doSub, ovfNext, signA, signB, signR;

  always_comb begin
    opA   = tmpNew;
    opB   = tmpOld;
    doSub = 1'b0;
    unique case (strb.aluOp)
      OP_SUB: doSub = 1'b1;
      OP_NEG: begin
        opA   = '0;
        opB   = tmpNew;
        doSub = 1'b1;
      end
      default: doSub = 1'b0;
    endcase
  end

  assign bXor = opB ^ {DATA_W{doSub}};

  rpn_cla #(.W(DATA_W)) uCla (
    .a   (opA),
    .b   (bXor),
    .cin (doSub),
    .sum (aluSum)
  );

  assign signA = opA[DATA_W-1];
  assign signB = opB[DATA_W-1];
  assign signR = aluSum[DATA_W-1];
  assign ovfNext = doSub ? ((signA ^ signB) & (signR ^ signA))
                         : (~(signA ^ signB) & (signR ^ signA));

  always_comb begin
    unique case (strb.pushSrc)
      SRC_ALU: pushData = aluSum;
      SRC_OLD: pushData = tmpOld;
      SRC_NEW: pushData = tmpNew;
      default: pushData = numIn;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp      <= '0;
      tmpNew  <= '0;
      tmpOld  <= '0;
      ovfFlag <= 1'b0;
    end else if (strb.clearEn) begin
      sp      <= '0;
      tmpNew  <= '0;
      tmpOld  <= '0;
      ovfFlag <= 1'b0;
    end else begin
      if (strb.pushEn) begin
        sp <= sp + CNT_W'(1);
      end else if (strb.popEn) begin
        sp     <= sp - CNT_W'(1);
        tmpNew <= mem[headIdx];
        tmpOld <= tmpNew;
      end
      if (strb.setOvf) ovfFlag <= ovfNext;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.pushEn && !strb.clearEn) mem[wrIdx] <= pushData;
  end

  assign isEmpty = (sp == '0);
  assign isFull  = (sp == CNT_W'(DEPTH));
  assign depth   = sp;
  assign topOut  = isEmpty ? '0 : mem[headIdx];

endmodule

// File: rtl/rpn_control.sv
module rpn_control
  import rpn_pkg::*;
#(
  parameter int DEPTH  = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pushKey,
  input  logic             popKey,
  input  logic             modeKey,
  input  logic             clearKey,
  input  logic [CNT_W-1:0] depth,
  input  logic             isFull,
  input  logic             isEmpty,
  output strobe_t          strb,
  output logic [1:0]       modeOut,
  output logic             busy
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_POP1, ST_POP2, ST_PUSHA, ST_PUSHB
  } state_t;

  state_t state, stateNext;
  mode_t  mode, modeNext;
  op_t    opReg, opNext;

  logic reqValid;
  op_t  reqOp;
  logic enough;

  // Command request decoded from the keys in modes 1 and 2
  always_comb begin
    reqValid = 1'b0;
    reqOp    = OP_ADD;
    if (mode == MODE_ARITH) begin
      if (pushKey)     begin reqValid = 1'b1; reqOp = OP_ADD;  end
      else if (popKey) begin reqValid = 1'b1; reqOp = OP_SUB;  end
    end else if (mode == MODE_EXTRA) begin
      if (pushKey)     begin reqValid = 1'b1; reqOp = OP_NEG;  end
      else if (popKey) begin reqValid = 1'b1; reqOp = OP_SWAP; end
    end
  end

  assign enough = (reqOp == OP_NEG) ? (depth >= CNT_W'(1)) : (depth >= CNT_W'(2));

  always_comb begin
    stateNext    = state;
    modeNext     = mode;
    opNext       = opReg;
    strb         = '0;
    strb.aluOp   = opReg;
    strb.pushSrc = SRC_SWITCH;

    if (clearKey) begin
      strb.clearEn = 1'b1;
      stateNext    = ST_IDLE;
      modeNext     = MODE_BASE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (mode == MODE_BASE) begin
            if (pushKey) begin
              strb.pushEn = !isFull;
            end else if (popKey) begin
              strb.popEn = !isEmpty;
            end else if (modeKey) begin
              modeNext = MODE_ARITH;
            end
          end else if (reqValid) begin
            modeNext = MODE_BASE;
            if (enough) begin
              opNext    = reqOp;
              stateNext = ST_POP1;
            end
          end else if (modeKey) begin
            modeNext = (mode == MODE_ARITH) ? MODE_EXTRA : MODE_BASE;
          end
        end
        ST_POP1: begin
          strb.popEn = 1'b1;
          stateNext  = (opReg == OP_NEG) ? ST_PUSHA : ST_POP2;
        end
        ST_POP2: begin
          strb.popEn = 1'b1;
          stateNext  = ST_PUSHA;
        end
        ST_PUSHA: begin
          strb.pushEn = 1'b1;
          if (opReg == OP_SWAP) begin
            strb.pushSrc = SRC_OLD;
            stateNext    = ST_PUSHB;
          end else begin
            strb.pushSrc = SRC_ALU;
            strb.setOvf  = 1'b1;
            stateNext    = ST_IDLE;
          end
        end
        ST_PUSHB: begin
          strb.pushEn  = 1'b1;
          strb.pushSrc = SRC_NEW;
          stateNext    = ST_IDLE;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      mode  <= MODE_BASE;
      opReg <= OP_ADD;
    end else begin
      state <= stateNext;
      mode  <= modeNext;
      opReg <= opNext;
    end
  end

  assign modeOut = mode;
  assign busy    = (state != ST_IDLE);

endmodule

// File: rtl/rpn_calc.sv
module rpn_calc
  import rpn_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pushKey,
  input  logic              popKey,
  input  logic              modeKey,
  input  logic              clearKey,
  input  logic [DATA_W-1:0] numIn,
  output logic [DATA_W-1:0] topOut,
  output logic [CNT_W-1:0]  depth,
  output logic              isEmpty,
  output logic              isFull,
  output logic              ovfFlag,
  output logic [1:0]        modeOut,
  output logic              busy
);

  strobe_t strb;

  rpn_control #(.DEPTH(DEPTH)) uCtrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .pushKey  (pushKey),
    .popKey   (popKey),
    .modeKey  (modeKey),
    .clearKey (clearKey),
    .depth    (depth),
    .isFull   (isFull),
    .isEmpty  (isEmpty),
    .strb     (strb),
    .modeOut  (modeOut),
    .busy     (busy)
  );

  rpn_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uData (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .numIn   (numIn),
    .topOut  (topOut),
    .depth   (depth),
    .isEmpty (isEmpty),
    .isFull  (isFull),
    .ovfFlag (ovfFlag)
  );

endmodule

// File: rtl/rpn_calc_chk.sv
module rpn_calc_chk #(
  parameter int DEPTH  = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pushKey,
  input logic             popKey,
  input logic             modeKey,
  input logic             clearKey,
  input logic [CNT_W-1:0] depth,
  input logic             isEmpty,
  input logic             isFull,
  input logic             ovfFlag,
  input logic [1:0]       modeOut,
  input logic             busy
);

  a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clearKey |=> (depth == '0) && isEmpty && (modeOut == 2'd0) && !ovfFlag && !busy);

  a_r2_mode_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !clearKey && !pushKey && !popKey && modeKey && modeOut == 2'd0)
      |=> (modeOut == 2'd1));

  a_r3_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !clearKey && modeOut == 2'd0 && pushKey && !isFull)
      |=> (depth == $past(depth) + CNT_W'(1)));

  a_r3_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !clearKey && modeOut == 2'd0 && pushKey && isFull) |=> $stable(depth));

  a_r4_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !clearKey && modeOut == 2'd0 && popKey && !pushKey && isEmpty) |=> isEmpty);

  a_r7_flag_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !clearKey) |=> $stable(ovfFlag));

  a_r10_mode_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (modeOut == 2'd0));

  a_r12_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (depth <= CNT_W'(DEPTH)) && (isFull == (depth == CNT_W'(DEPTH))));

endmodule

bind rpn_calc rpn_calc_chk #(.DEPTH(DEPTH)) uChk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pushKey  (pushKey),
  .popKey   (popKey),
  .modeKey  (modeKey),
  .clearKey (clearKey),
  .depth    (depth),
  .isEmpty  (isEmpty),
  .isFull   (isFull),
  .ovfFlag  (ovfFlag),
  .modeOut  (modeOut),
  .busy     (busy)
);

// File: tb/sim_rpn_calc.sv
module sim_rpn_calc;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pushKey = 1'b0, popKey = 1'b0, modeKey = 1'b0, clearKey = 1'b0;
  logic [7:0] numIn = '0;
  logic [7:0] topOut;
  logic [5:0] depth;
  logic       isEmpty, isFull, ovfFlag, busy;
  logic [1:0] modeOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  rpn_calc u0 (
    .clk(clk), .rst_n(rst_n), .pushKey(pushKey), .popKey(popKey),
    .modeKey(modeKey), .clearKey(clearKey), .numIn(numIn),
    .topOut(topOut), .depth(depth), .isEmpty(isEmpty), .isFull(isFull),
    .ovfFlag(ovfFlag), .modeOut(modeOut), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // key: 0 push, 1 pop, 2 mode, 3 clear; returns busy cycles
  task automatic press(input int key, output int cyc);
    pushKey  = (key == 0);
    popKey   = (key == 1);
    modeKey  = (key == 2);
    clearKey = (key == 3);
    @(negedge clk);
    pushKey = 0; popKey = 0; modeKey = 0; clearKey = 0;
    cyc = 0;
    while (busy && cyc < 20) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic tap(input int key);
    int c;
    press(key, c);
  endtask

  task automatic pushVal(input int v);
    numIn = 8'(v);
    tap(0);
  endtask

  // op: 0 add, 1 sub, 2 neg, 3 swap; returns busy cycles
  task automatic runOp(input int op, output int cyc);
    tap(2);
    if (op >= 2) tap(2);
    press(op[0] ? 1 : 0, cyc);
  endtask

  function automatic int sx(input int v);
    int t;
    t = v & 255;
    return (t > 127) ? t - 256 : t;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R12 reset state
    check(depth == 0 && isEmpty, "R1 reset depth", int'(depth), 0);
    check(modeOut == 0 && !ovfFlag && !busy, "R1 reset mode/flag", int'(modeOut), 0);
    check(topOut == 0, "R12 empty top", int'(topOut), 0);

    // R2 mode cycle
    tap(2); check(modeOut == 1, "R2 mode 0->1", int'(modeOut), 1);
    tap(2); check(modeOut == 2, "R2 mode 1->2", int'(modeOut), 2);
    tap(2); check(modeOut == 0, "R2 mode 2->0", int'(modeOut), 0);

    // R3 fill, R11 push takes no busy cycles
    for (int i = 0; i < 32; i++) begin
      numIn = 8'(i * 7 + 3);
      press(0, c);
      check(c == 0, "R11 push busy", c, 0);
      check(depth == 6'(i + 1) && topOut == 8'(i * 7 + 3), "R3 push", int'(topOut), (i * 7 + 3) & 255);
    end
    check(isFull, "R12 full flag", int'(isFull), 1);
    pushVal(200);
    check(depth == 32, "R3 push on full depth", int'(depth), 32);
    check(topOut == 8'(31 * 7 + 3), "R3 push on full top", int'(topOut), (31 * 7 + 3) & 255);

    // R4 drain
    for (int i = 31; i >= 0; i--) begin
      check(topOut == 8'(i * 7 + 3), "R4 pop order", int'(topOut), (i * 7 + 3) & 255);
      tap(1);
      check(depth == 6'(i), "R4 pop depth", int'(depth), i);
    end
    tap(1);
    check(depth == 0 && isEmpty, "R4 pop on empty", int'(depth), 0);

    // R5/R6/R7 add and subtract sweep
    for (int op = 0; op < 2; op++) begin
      for (int i = 0; i < 23; i++) begin
        for (int j = 0; j < 23; j++) begin
          int a, b, r;
          a = (i < 20) ? i * 13 : (i == 20 ? 127 : (i == 21 ? 128 : 255));
          b = (j < 20) ? j * 13 : (j == 20 ? 127 : (j == 21 ? 128 : 255));
          tap(3);
          pushVal(a);
          pushVal(b);
          runOp(op, c);
          r = (op == 0) ? sx(a) + sx(b) : sx(a) - sx(b);
          if (op == 0) begin
            check(topOut == 8'(r) && depth == 1, "R5 add", int'(topOut), r & 255);
          end else begin
            check(topOut == 8'(r) && depth == 1, "R6 sub", int'(topOut), r & 255);
          end
          check(ovfFlag == (r > 127 || r < -128), "R7 overflow", int'(ovfFlag),
                int'(r > 127 || r < -128));
          check(c == 3, "R11 add/sub busy", c, 3);
          check(modeOut == 0, "R10 mode after op", int'(modeOut), 0);
        end
      end
    end

    // R8 negate sweep
    for (int v = 0; v < 256; v++) begin
      tap(3);
      pushVal(v);
      runOp(2, c);
      check(topOut == 8'(-v) && depth == 1, "R8 negate", int'(topOut), (-v) & 255);
      check(ovfFlag == (v == 128), "R8 negate overflow", int'(ovfFlag), int'(v == 128));
      check(c == 2, "R11 negate busy", c, 2);
    end

    // R9 exchange
    tap(3);
    pushVal(11); pushVal(22); pushVal(33);
    runOp(3, c);
    check(c == 4, "R11 swap busy", c, 4);
    check(topOut == 22 && depth == 3, "R9 swap top", int'(topOut), 22);
    tap(1);
    check(topOut == 33, "R9 swap second", int'(topOut), 33);
    tap(1);
    check(topOut == 11, "R9 swap untouched", int'(topOut), 11);

    // R7 flag kept through push/pop/swap; R10 short stack ignored
    tap(3);
    pushVal(100); pushVal(100);
    runOp(0, c);
    check(ovfFlag && topOut == 8'd200, "R7 set by add", int'(ovfFlag), 1);
    runOp(0, c);
    check(depth == 1 && topOut == 8'd200 && ovfFlag, "R10 add short ignored", int'(depth), 1);
    check(modeOut == 0 && c == 0, "R10 mode back", int'(modeOut), 0);
    runOp(1, c);
    check(depth == 1 && topOut == 8'd200 && ovfFlag, "R10 sub short ignored", int'(depth), 1);
    runOp(3, c);
    check(depth == 1 && topOut == 8'd200 && modeOut == 0, "R10 swap short ignored", int'(depth), 1);
    pushVal(3);
    check(ovfFlag, "R7 push keeps flag", int'(ovfFlag), 1);
    runOp(3, c);
    check(ovfFlag && topOut == 8'd200, "R7 swap keeps flag", int'(ovfFlag), 1);
    tap(1);
    check(ovfFlag, "R7 pop keeps flag", int'(ovfFlag), 1);
    tap(1);
    runOp(2, c);
    check(depth == 0 && modeOut == 0 && ovfFlag, "R10 negate empty ignored", int'(depth), 0);

    // R1 clear during a busy sequence
    pushVal(1); pushVal(2);
    tap(2);
    pushKey = 1;
    @(negedge clk);
    pushKey = 0;
    check(busy, "R11 busy after add key", int'(busy), 1);
    clearKey = 1;
    @(negedge clk);
    clearKey = 0;
    check(depth == 0 && !busy && modeOut == 0 && !ovfFlag, "R1 clear mid-op", int'(depth), 0);
    @(negedge clk);
    check(depth == 0 && topOut == 0, "R1 stays clear", int'(depth), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule